// File: doc/BRIEF.md
# Lane Code-Group Synchronizer

This block is the per-lane receive controller that brings a serial link lane into code-group lock. It sits after an 8b/10b decoder, which is not part of this block. For each decoded character the decoder supplies a strobe, a flag saying the character is the K28.5 comma, and one combined error flag. The error flag is set for a disparity error or for a code that is not in the decode table.

Lock is reached in two phases. While hunting, the block holds its active-low synchronization request low and counts error-free commas in a row. After the fourth comma it releases the request. It then needs four further error-free characters of any kind before it declares lock. A bad character during this check phase sends it back to hunting without raising an alarm.

Once locked, a leaky error counter watches the character stream. Three bad characters that are not worked off by runs of good characters cause loss of lock. On loss the request is driven low again, lock is withdrawn and a sticky alarm is set.

Top module: `cgs_lane_sync`

## Requirements
- R1: After a synchronous reset, `sync_n` is 0, `cgs_done` is 0 and `cgs_err` is 0.
- R2: `sync_n` stays 0 until RUN_K (default 4) consecutive strobed characters with `chr_is_k`=1 and `chr_bad`=0 have arrived. It goes to 1 on the clock edge that samples the last of them.
- R3: While hunting, a strobed character that is not a comma, or that has `chr_bad`=1, restarts the comma count from zero.
- R4: After the request is released, RUN_CHK (default 4) error-free strobed characters of any type set `cgs_done` to 1 on the edge that samples the last of them.
- R5: A character with `chr_bad`=1 during the check phase returns the block to hunting. On that edge `sync_n` goes to 0, `cgs_done` stays 0 and `cgs_err` is unchanged.
- R6: While locked, each bad character raises an invalid count by one. The bad character that brings the count to ERR_LIMIT (default 3) causes loss of lock on the edge that samples it: `sync_n` goes to 0, `cgs_done` goes to 0 and `cgs_err` goes to 1.
- R7: While locked, each run of WIN (default 4) consecutive good characters lowers the invalid count by one, never below zero. A bad character restarts the good run.
- R8: `cgs_err` stays 1 until the next reset, including through a later re-lock.
- R9: Cycles with `chr_vld`=0 change no output and no count, whatever the other inputs carry.
- R10: After loss of lock, hunting starts with a comma count of zero, so a full RUN_K commas are needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_vld | input | 1 | A decoded character is present this cycle |
| chr_is_k | input | 1 | Character is the K28.5 comma |
| chr_bad | input | 1 | Disparity or not-in-table error on this character |
| sync_n | output | 1 | Active-low synchronization request (0 = request) |
| cgs_done | output | 1 | Code-group lock declared |
| cgs_err | output | 1 | Sticky alarm for loss of lock |

## Verification
The assertions check three rules on every cycle: lock is never shown while the request is low, the alarm never clears outside reset, and idle cycles leave all outputs unchanged. They also check that a release is always preceded by a clean comma and that the invalid count stays below its limit. Only the bench scenarios can show the exact counting: that a comma run restarts when broken, that the check phase needs exactly four characters, and that good runs drain the invalid count down to a floor of zero. The same goes for the edge on which each output changes.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOCK  = 2'd2
  } cgs_state_t;

endpackage

// File: rtl/cgs_run_cnt.sv
// Counts qualified events in a row; clear has priority; pulses hit on the last one.
module cgs_run_cnt #(
  parameter int RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN - 1);

  logic [CW-1:0] cnt_q;

  assign hit = !clr && inc && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || hit) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(RUN));

  p_run_clear_r3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/cgs_err_window.sv
// Leaky invalid-character counter used while locked.
module cgs_err_window #(
  parameter int ERR_LIMIT = 3,
  parameter int WIN       = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic vld,
  input  logic bad,
  output logic lost
);
  localparam int ICW = $clog2(ERR_LIMIT + 1);
  localparam int GCW = $clog2(WIN + 1);
  localparam logic [ICW-1:0] IC_LAST = ICW'(ERR_LIMIT - 1);
  localparam logic [GCW-1:0] GC_LAST = GCW'(WIN - 1);

  logic [ICW-1:0] ic_q;
  logic [GCW-1:0] gc_q;

  assign lost = !clr && vld && bad && (ic_q == IC_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ic_q <= '0;
      gc_q <= '0;
    end else if (vld) begin
      if (bad) begin
        gc_q <= '0;
        ic_q <= lost ? '0 : ic_q + 1'b1;
      end else if (gc_q == GC_LAST) begin
        gc_q <= '0;
        if (ic_q != '0) ic_q <= ic_q - 1'b1;
      end else begin
        gc_q <= gc_q + 1'b1;
      end
    end
  end

  p_window_bound_r6: assert property (@(posedge clk) disable iff (rst)
    ic_q < ICW'(ERR_LIMIT));

  p_decay_floor_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr && vld && !bad && ic_q == '0) |=> (ic_q == '0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr && !vld) |=> ($stable(ic_q) && $stable(gc_q)));

endmodule

// File: rtl/cgs_lane_sync.sv
module cgs_lane_sync #(
  parameter int RUN_K     = 4,
  parameter int RUN_CHK   = 4,
  parameter int ERR_LIMIT = 3,
  parameter int WIN       = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic chr_vld,
  input  logic chr_is_k,
  input  logic chr_bad,
  output logic sync_n,
  output logic cgs_done,
  output logic cgs_err
);
  import cgs_pkg::*;

  cgs_state_t state_q, state_d;
  logic       good_k, good_chr;
  logic       k_hit, chk_hit, lost;
  logic       k_clr, chk_clr, win_clr;
  logic       sync_n_q, done_q, err_q, err_d;

  assign good_k   = chr_vld && chr_is_k && !chr_bad;
  assign good_chr = chr_vld && !chr_bad;

  assign k_clr   = (state_q != ST_HUNT) || (chr_vld && !good_k);
  assign chk_clr = (state_q != ST_CHECK);
  assign win_clr = (state_q != ST_LOCK);

  cgs_run_cnt #(.RUN(RUN_K)) u_kcnt (
    .clk(clk), .rst(rst), .clr(k_clr), .inc(good_k), .hit(k_hit)
  );

  cgs_run_cnt #(.RUN(RUN_CHK)) u_chkcnt (
    .clk(clk), .rst(rst), .clr(chk_clr), .inc(good_chr), .hit(chk_hit)
  );

  cgs_err_window #(.ERR_LIMIT(ERR_LIMIT), .WIN(WIN)) u_win (
    .clk(clk), .rst(rst), .clr(win_clr), .vld(chr_vld), .bad(chr_bad), .lost(lost)
  );

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    unique case (state_q)
      ST_HUNT:  if (k_hit) state_d = ST_CHECK;
      ST_CHECK: begin
        if (chr_vld && chr_bad) state_d = ST_HUNT;
        else if (chk_hit)       state_d = ST_LOCK;
      end
      ST_LOCK: begin
        if (lost) begin
          state_d = ST_HUNT;
          err_d   = 1'b1;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_HUNT;
      sync_n_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      sync_n_q <= (state_d != ST_HUNT);
      done_q   <= (state_d == ST_LOCK);
      err_q    <= err_d;
    end
  end

  assign sync_n   = sync_n_q;
  assign cgs_done = done_q;
  assign cgs_err  = err_q;

  p_done_released_r4: assert property (@(posedge clk) disable iff (rst)
    cgs_done |-> sync_n);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    cgs_err |=> cgs_err);

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !chr_vld |=> $stable({sync_n, cgs_done, cgs_err}));

  p_release_on_comma_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> $past(chr_vld && chr_is_k && !chr_bad));

  p_loss_drops_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cgs_err) |-> (!sync_n && !cgs_done));

endmodule

// File: tb/tb_cgs_lane_sync.sv
module tb_cgs_lane_sync;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chr_vld = 1'b0, chr_is_k = 1'b0, chr_bad = 1'b0;
  logic sync_n, cgs_done, cgs_err;

  always #2.5 clk = ~clk;

  cgs_lane_sync dut (
    .clk(clk), .rst(rst), .chr_vld(chr_vld), .chr_is_k(chr_is_k), .chr_bad(chr_bad),
    .sync_n(sync_n), .cgs_done(cgs_done), .cgs_err(cgs_err)
  );

  typedef struct {
    logic  sn;
    logic  dn;
    logic  er;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Behavioural model built from the requirements: 0 hunt, 1 check, 2 locked
  int m_st = 0, m_kc = 0, m_cc = 0, m_ic = 0, m_gc = 0;
  bit m_err = 0;

  task automatic model_reset();
    m_st = 0; m_kc = 0; m_cc = 0; m_ic = 0; m_gc = 0; m_err = 0;
  endtask

  task automatic model_step(input bit v, input bit k, input bit b);
    if (!v) return;
    case (m_st)
      0: begin
        if (k && !b) begin
          m_kc++;
          if (m_kc == 4) begin m_st = 1; m_kc = 0; m_cc = 0; end
        end else m_kc = 0;
      end
      1: begin
        if (b) begin m_st = 0; m_kc = 0; end
        else begin
          m_cc++;
          if (m_cc == 4) begin m_st = 2; m_ic = 0; m_gc = 0; end
        end
      end
      default: begin
        if (b) begin
          m_gc = 0; m_ic++;
          if (m_ic == 3) begin m_st = 0; m_kc = 0; m_err = 1; end
        end else begin
          m_gc++;
          if (m_gc == 4) begin m_gc = 0; if (m_ic > 0) m_ic--; end
        end
      end
    endcase
  endtask

  // Driver: one character per cycle, expectation queued for the monitor
  task automatic send(input bit v, input bit k, input bit b, input string req);
    exp_t e;
    @(negedge clk);
    chr_vld = v; chr_is_k = k; chr_bad = b;
    model_step(v, k, b);
    e.sn = (m_st != 0); e.dn = (m_st == 2); e.er = m_err; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic send_n(input int n, input bit k, input bit b, input string req);
    for (int i = 0; i < n; i++) send(1'b1, k, b, req);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic check_now(input logic sn, input logic dn, input logic er, input string req);
    checks++;
    if (sync_n !== sn || cgs_done !== dn || cgs_err !== er) begin
      errors++;
      $display("FAIL %s: got sync_n=%b done=%b err=%b expected %b %b %b",
               req, sync_n, cgs_done, cgs_err, sn, dn, er);
    end
  endtask

  task automatic do_reset();
    drain();
    @(negedge clk);
    rst = 1'b1; chr_vld = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check_now(1'b0, 1'b0, 1'b0, "R1 reset state");
  endtask

  // Monitor: compares one queued expectation per clock after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check_now(e.sn, e.dn, e.er, e.req);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: idle cycles with comma and error lines toggling
    send(1'b0, 1'b1, 1'b0, "R9 idle in hunt");
    send(1'b0, 1'b1, 1'b1, "R9 idle in hunt");
    // R3: broken comma runs
    send_n(3, 1'b1, 1'b0, "R3 partial comma run");
    send(1'b1, 1'b0, 1'b0, "R3 data breaks run");
    send_n(3, 1'b1, 1'b0, "R3 partial comma run");
    send(1'b1, 1'b1, 1'b1, "R3 bad comma breaks run");
    // R2: clean run of four commas with an idle gap inside
    send_n(2, 1'b1, 1'b0, "R2 comma run");
    send(1'b0, 1'b0, 1'b0, "R9 idle inside run");
    send_n(2, 1'b1, 1'b0, "R2 release on fourth comma");
    // R5: failure in check phase
    send_n(2, 1'b0, 1'b0, "R5 check phase data");
    send(1'b1, 1'b0, 1'b1, "R5 bad char in check");
    // R4: full lock
    send_n(4, 1'b1, 1'b0, "R2 comma run");
    send_n(3, 1'b0, 1'b0, "R4 check phase data");
    send(1'b0, 1'b0, 1'b1, "R9 idle in check");
    send(1'b1, 1'b1, 1'b0, "R4 lock on fourth valid");
    // R6/R7: leaky counter with a broken good run
    send(1'b1, 1'b0, 1'b1, "R6 first bad");
    send(1'b1, 1'b0, 1'b1, "R6 second bad");
    send_n(4, 1'b0, 1'b0, "R7 good run decays count");
    send(1'b1, 1'b0, 1'b1, "R7 bad after decay");
    send_n(3, 1'b0, 1'b0, "R7 short good run");
    send(1'b1, 1'b1, 1'b1, "R6 third bad loses lock");
    // R10: fresh hunt after loss
    send_n(3, 1'b1, 1'b0, "R10 three commas not enough");
    send(1'b1, 1'b0, 1'b0, "R10 data restarts");
    send_n(4, 1'b1, 1'b0, "R10 full comma run");
    send_n(4, 1'b0, 1'b0, "R8 relock keeps alarm");
    // R7 floor: long good run then two bad stays locked
    send_n(8, 1'b0, 1'b0, "R7 floor at zero");
    send_n(2, 1'b0, 1'b1, "R7 two bad after floor");
    send_n(4, 1'b0, 1'b0, "R7 decay to one");
    send(1'b1, 1'b0, 1'b1, "R6 count two");
    send(1'b0, 1'b0, 1'b1, "R9 idle in lock");
    send(1'b1, 1'b0, 1'b1, "R6 count three loses lock");
    drain();
    // R8: only reset clears the alarm
    do_reset();
    send_n(4, 1'b1, 1'b0, "R2 comma run after reset");
    send_n(4, 1'b0, 1'b0, "R4 lock after reset");
    drain();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule